// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog with three 16-bit registers on a simple synchronous write port and a combinational read port. Software writes a timeout code and sets an enable bit in the control register. From then on it must prove it is alive by writing a two-word key to the service register before the countdown runs out. If the countdown expires, the block pulses a system reset output, clears its own control state and records in a read-only status register that the last reset came from a timeout and not from power-on.

Time is counted in half-second units. A prescaler of `CLKS_PER_HALF_SEC` clocks produces each unit, and a timeout code `n` gives a period of `n+1` units. A new code written while the timer runs only takes effect at the next enable or key reload.

Top module: `keyed_wdog`

## Requirements
- R1: After `rst_n` is low, control (offset 0x0) reads 0x0000, status (offset 0x4) reads 0x0010 (bit 4 = power-on cause), and `wdog_rst` is low.
- R2: Control bit 2 is the enable. While it is 0 the countdown does not run and `wdog_rst` stays low.
- R3: Control bits 15:8 hold the code WT. If a control write sets bit 2 while the timer is disabled, `wdog_rst` goes high exactly (WT+1)*CLKS_PER_HALF_SEC cycles after that write edge, unless the timer is serviced.
- R4: `wdog_rst` is high for exactly one cycle. In that same cycle control reads 0x0000 and status reads 0x0001 (bit 0 = timeout cause, bit 4 cleared).
- R5: A service write (offset 0x2) of 0x5555 followed by a next service write of 0xAAAA reloads the countdown. `wdog_rst` then rises (WT+1)*CLKS_PER_HALF_SEC cycles after the 0xAAAA write edge.
- R6: A 0xAAAA service write whose preceding service write was not 0x5555, and any service write of another value, do not reload the countdown. Any such write disarms the key sequence.
- R7: Once bit 2 is set, a control write with bit 2 clear leaves it set. Only `rst_n` or a timeout clears it.
- R8: Changing WT while the timer runs does not alter the count in progress. The new WT applies from the next reload.
- R9: Control bits 0, 1, 3 and 7 are stored and read back, and they have no effect on timing. Bits 6:4 read 0. The service register reads 0x0000.
- R10: Writes to status (offset 0x4) are ignored, and unmapped offsets read 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| wdog_rst | output | 1 | One-cycle system reset request on timeout |

## Verification
A corrupted prescaler or countdown shows up only as a `wdog_rst` edge that arrives earlier or later than the computed cycle. The bench therefore measures the exact cycle distance from the enabling or servicing write to the pulse, for every WT in a small sweep and at the largest code. A stuck or wrongly cleared key tracker is invisible until the next timeout, which then lands at the un-reloaded or reloaded position. Each malformed key sequence is followed by a timing measurement for this reason. Lost status or sticky-enable state can be read back at once through the register port.

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int CLKS_PER_HALF_SEC = 25_000_000,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              wdog_rst
);
  localparam int PW = (CLKS_PER_HALF_SEC > 1) ? $clog2(CLKS_PER_HALF_SEC) : 1;
  localparam logic [PW-1:0]     PRE_LAST  = PW'(CLKS_PER_HALF_SEC - 1);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SVC     = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STAT    = ADDR_W'(4);
  localparam logic [15:0]       CTRL_MASK = 16'hFF8F;
  localparam logic [15:0]       KEY_ARM   = 16'h5555;
  localparam logic [15:0]       KEY_FIRE  = 16'hAAAA;
  localparam logic [15:0]       ST_POR    = 16'h0010;
  localparam logic [15:0]       ST_TMO    = 16'h0001;

  logic [15:0]   ctrl, status;
  logic          armed;
  logic [7:0]    cnt;
  logic [PW-1:0] pre;

  logic en, ctrl_wr, svc_wr, key_arm, key_fire, en_rise, tick, expire;
  logic [7:0] wt;

  assign en       = ctrl[2];
  assign wt       = ctrl[15:8];
  assign ctrl_wr  = wr_en && (addr == A_CTRL);
  assign svc_wr   = wr_en && (addr == A_SVC);
  assign key_arm  = svc_wr && (wdata == KEY_ARM);
  assign key_fire = svc_wr && (wdata == KEY_FIRE) && armed;
  assign en_rise  = ctrl_wr && wdata[2] && !en;
  assign tick     = en && (pre == PRE_LAST);
  assign expire   = tick && (cnt == 8'd0) && !key_fire;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrl;
      A_STAT:  rdata = status;
      default: rdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= 16'h0000;
      status   <= ST_POR;
      armed    <= 1'b0;
      cnt      <= 8'd0;
      pre      <= '0;
      wdog_rst <= 1'b0;
    end else begin
      wdog_rst <= expire;
      if (expire) begin
        ctrl   <= 16'h0000;
        status <= ST_TMO;
        armed  <= 1'b0;
        cnt    <= 8'd0;
        pre    <= '0;
      end else begin
        if (ctrl_wr) ctrl <= (wdata & CTRL_MASK) | {13'b0, en, 2'b0};
        if (svc_wr)  armed <= key_arm;
        if (key_fire) begin
          cnt <= wt;
          pre <= '0;
        end else if (en_rise) begin
          cnt <= wdata[15:8];
          pre <= '0;
        end else if (en) begin
          if (tick) begin
            pre <= '0;
            cnt <= cnt - 8'd1;
          end else begin
            pre <= pre + PW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       wdata,
  input logic              wdog_rst,
  input logic [15:0]       ctrl,
  input logic [15:0]       status,
  input logic              armed,
  input logic [7:0]        cnt
);
  p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[2] |=> !wdog_rst);

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |=> !wdog_rst);

  p_cause_logged_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |-> (status == 16'h0001) && (ctrl == 16'h0000));

  p_key_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(2) && wdata == 16'hAAAA && armed) |=> (cnt == $past(ctrl[15:8])));

  p_en_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[2] |=> (ctrl[2] || wdog_rst));

  p_status_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(4)) |=> ($stable(status) || wdog_rst));
endmodule

bind keyed_wdog keyed_wdog_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .wdog_rst(wdog_rst), .ctrl(ctrl), .status(status), .armed(armed), .cnt(cnt)
);

// File: tb/sim_keyed_wdog.sv
`timescale 1ns/1ps
module sim_keyed_wdog;
  localparam int CPH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;
  logic        wdog_rst;

  int checks = 0;
  int fails = 0;

  keyed_wdog #(.CLKS_PER_HALF_SEC(CPH), .ADDR_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wdog_rst(wdog_rst)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, got, got, exp, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    addr = a;
    #1 v = int'(rdata);
  endtask

  task automatic measure(input int limit, output int k);
    k = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (wdog_rst) begin
        k = i;
        break;
      end
    end
  endtask

  initial begin
    #(20.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v, k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd4, v); chk("R1 status", v, 16'h0010);
    chk("R1 wdog_rst", int'(wdog_rst), 0);

    // R9 flags readback, reserved bits zero, service reads zero
    wr(3'd0, 16'h3CFB);
    rd(3'd0, v); chk("R9 ctrl flags", v, 16'h3C8B);
    rd(3'd2, v); chk("R9 service reads 0", v, 0);
    rd(3'd6, v); chk("R10 unmapped reads 0", v, 0);

    // R2 disabled: no reset
    measure(200, k); chk("R2 no reset while disabled", k, -1);

    // R10 status read-only
    wr(3'd4, 16'hFFFF);
    rd(3'd4, v); chk("R10 status unchanged", v, 16'h0010);

    // R3/R4 sweep over timeout codes
    for (int wt = 0; wt < 9; wt++) begin
      int code;
      code = (wt == 8) ? 255 : wt;
      wr(3'd0, {code[7:0], 8'h04});
      measure(2000, k); chk("R3 timeout cycles", k, (code + 1) * CPH);
      #1 v = int'(u0.rdata); // placeholder avoided below
      addr = 3'd0; #1 chk("R4 ctrl cleared", int'(rdata), 0);
      addr = 3'd4; #1 chk("R4 status timeout", int'(rdata), 16'h0001);
      @(negedge clk); chk("R4 single pulse", int'(wdog_rst), 0);
    end

    // R9 flags have no timing effect
    wr(3'd0, 16'h028F);
    measure(2000, k); chk("R9 timing with flags", k, 3 * CPH);

    // R5 repeated good service
    wr(3'd0, 16'h0304);
    repeat (9) @(negedge clk);
    wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
    repeat (9) @(negedge clk);
    wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
    measure(2000, k); chk("R5 reload after key", k, 4 * CPH);

    // R6 lone 0xAAAA
    wr(3'd0, 16'h0304);
    repeat (5) @(negedge clk);
    wr(3'd2, 16'hAAAA);
    measure(2000, k); chk("R6 lone AAAA no reload", k, 4 * CPH - 6);

    // R6 interrupted key
    wr(3'd0, 16'h0304);
    repeat (2) @(negedge clk);
    wr(3'd2, 16'h5555); wr(3'd2, 16'h1234); wr(3'd2, 16'hAAAA);
    measure(2000, k); chk("R6 broken key no reload", k, 4 * CPH - 5);

    // R7 sticky enable
    wr(3'd0, 16'h0304);
    wr(3'd0, 16'h0300);
    rd(3'd0, v); chk("R7 enable stays set", v, 16'h0304);
    measure(2000, k); chk("R7 still times out", k, 4 * CPH - 2);

    // R8 code change mid-count
    wr(3'd0, 16'h0104);
    wr(3'd0, 16'h0504);
    measure(2000, k); chk("R8 running count kept", k, 2 * CPH - 1);
    wr(3'd0, 16'h0104);
    wr(3'd0, 16'h0504);
    wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
    measure(2000, k); chk("R8 new code on reload", k, 6 * CPH);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule